// File: doc/BRIEF.md
# Single-Wire Search Step Unit

This block carries out one decision step of the binary address search on a single-wire bus. Given a preferred branch bit, it asks the time-slot master for two read slots. The first read returns the address bit that the responding devices hold. The second returns the complement of that bit. From the pair it either stops with an error or picks a branch. It then asks for one write slot that carries the chosen branch bit, so that devices on the other branch drop out.

The time-slot master is reached through a request/acknowledge pair. The unit holds `slot_req` high, with the slot kind and write value, until the master pulses `slot_ack`. For a read slot the sampled line level comes with that acknowledge. When a step ends, the unit pulses `done` for one cycle and presents a 3-bit status. The status stays on the output until the next step ends. Keeping the search position over the whole address, sending the search command and tracking the last discrepancy are the job of the logic that drives this block.

Top module: `search_step`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `slot_req`, `done` and `err` are 0 and `status` is 3'b000.
- R2: A `start` sampled while idle latches `dir_in`. From the next cycle `slot_req` is high with `slot_write`=0 (read slot), and it stays high until `slot_ack`.
- R3: After the first read is acknowledged, a second read slot is requested in the next cycle. The first sampled bit is the address bit and the second is the complement bit.
- R4: If both sampled bits are 1, no write slot is requested. `done` rises in the cycle after the second acknowledge, with `status`=3'b011 and `err`=1.
- R5: If both sampled bits are 0, a write slot (`slot_write`=1) carrying the latched preferred bit on `slot_wbit` is requested. The status becomes 3'b100 if that bit is 1 and 3'b000 otherwise.
- R6: If exactly one sampled bit is 1, the preferred bit is overridden and the address bit is written. The status becomes 3'b101 when the address bit is 1 and 3'b010 when it is 0. While a write request waits, `slot_wbit` is held steady.
- R7: Status field layout: bit 0 is the address bit, bit 1 is the complement bit and bit 2 is the branch taken. The status is held until the next step completes.
- R8: `done` is a single-cycle pulse in the cycle after the write slot is acknowledged, or after the second read in the error case. `err` is 0 whenever `done` is 0. `busy` is high from the cycle after start until `done` inclusive.
- R9: `start` while busy (including the `done` cycle) is ignored. `dir_in` changes after the step begins do not alter the written bit or the status.
- R10: `slot_ack` while no slot is requested is ignored and leaves the unit idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one search step when idle |
| dir_in | input | 1 | Preferred branch bit, latched at start |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | {branch taken, complement bit, address bit} |
| err | output | 1 | High with done when both bits read as 1 |
| slot_req | output | 1 | Time-slot request, held until acknowledged |
| slot_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | One-cycle slot completion from the slot master |
| slot_rbit | input | 1 | Sampled line level, valid with slot_ack on a read slot |

## Verification
The hardest case to reach is a late change of the preferred bit. This means a `start` repeated, with `dir_in` inverted, throughout a step whose branch depends on that bit. The stimulus holds `start` high and toggles `dir_in` over the whole step, including the `done` cycle. The written bit must then still match the bit latched at the first edge. The responder model also varies its acknowledge latency from zero to several cycles, so that `slot_wbit` has to stay steady across a held write request. It fires acknowledges while no request is up.

// File: rtl/search_step_pkg.sv
// Shared types for the search step unit.
// Assumes: one step at a time; phase encoding is private to the unit.
package search_step_pkg;
    localparam int STAT_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_RD_ID  = 3'd1,
        PH_RD_CMP = 3'd2,
        PH_WR     = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    // Status layout: {branch taken, complement bit, address bit}
    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } stat_t;

    localparam stat_t STAT_ABORT = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
endpackage

// File: rtl/search_step_decide.sv
// Branch decision for one search step.
// Does: flags the both-ones abort and picks the branch from the bit pair.
// Assumes: inputs are valid whenever the sequencer consumes the outputs.
module search_step_decide (
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic pref_bit,
    output logic abort,
    output logic dir_take
);
    // Purpose: decide abort and branch from the sampled pair.
    always_comb begin
        abort    = id_bit & cmp_bit;
        dir_take = (id_bit ^ cmp_bit) ? id_bit : pref_bit;
    end
endmodule

// File: rtl/search_step_seq.sv
// Sequencer for one search step: read, read, optional write, done.
// Does: latches the preferred bit, captures the two read bits and stores the status.
// Assumes: slot_ack is only meaningful while a slot is being requested.
module search_step_seq
    import search_step_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   dir_in,
    input  logic   slot_ack,
    input  logic   slot_rbit,
    input  logic   abort,
    input  logic   dir_take,
    output phase_t phase,
    output logic   id_q,
    output logic   pref_q,
    output logic   wdir_q,
    output stat_t  status_q,
    output logic   err_q
);
    logic cmp_q;

    // Purpose: step the phase machine and capture bits and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            id_q     <= 1'b0;
            cmp_q    <= 1'b0;
            pref_q   <= 1'b0;
            wdir_q   <= 1'b0;
            status_q <= '0;
            err_q    <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    pref_q <= dir_in;
                    phase  <= PH_RD_ID;
                end
                PH_RD_ID: if (slot_ack) begin
                    id_q  <= slot_rbit;
                    phase <= PH_RD_CMP;
                end
                PH_RD_CMP: if (slot_ack) begin
                    cmp_q <= slot_rbit;
                    if (abort) begin
                        status_q <= STAT_ABORT;
                        err_q    <= 1'b1;
                        phase    <= PH_DONE;
                    end else begin
                        wdir_q <= dir_take;
                        phase  <= PH_WR;
                    end
                end
                PH_WR: if (slot_ack) begin
                    status_q <= '{dir: wdir_q, cmp: cmp_q, id: id_q};
                    err_q    <= 1'b0;
                    phase    <= PH_DONE;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_ERR_SKIPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RD_CMP && slot_ack && id_q && slot_rbit) |=> (phase == PH_DONE)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(pref_q)); // R9
    AST_WBIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WR && !slot_ack) |=> (phase == PH_WR && $stable(wdir_q))); // R6
endmodule

// File: rtl/search_step.sv
// Top of the search step unit.
// Does: one address-search decision using two read slots and one write slot.
// Assumes: the slot master pulses slot_ack for one cycle per requested slot.
module search_step
    import search_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_in,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] status,
    output logic              err,
    output logic              slot_req,
    output logic              slot_write,
    output logic              slot_wbit,
    input  logic              slot_ack,
    input  logic              slot_rbit
);
    phase_t phase;
    logic   id_q, pref_q, wdir_q, err_q, abort, dir_take;
    stat_t  status_q;

    search_step_decide u_decide (
        .id_bit   (id_q),
        .cmp_bit  (slot_rbit),
        .pref_bit (pref_q),
        .abort    (abort),
        .dir_take (dir_take)
    );

    search_step_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir_in    (dir_in),
        .slot_ack  (slot_ack),
        .slot_rbit (slot_rbit),
        .abort     (abort),
        .dir_take  (dir_take),
        .phase     (phase),
        .id_q      (id_q),
        .pref_q    (pref_q),
        .wdir_q    (wdir_q),
        .status_q  (status_q),
        .err_q     (err_q)
    );

    // Purpose: decode the phase into the handshake and status outputs.
    always_comb begin
        busy       = (phase != PH_IDLE);
        done       = (phase == PH_DONE);
        slot_req   = (phase == PH_RD_ID) || (phase == PH_RD_CMP) || (phase == PH_WR);
        slot_write = (phase == PH_WR);
        slot_wbit  = wdir_q;
        status     = status_q;
        err        = done && err_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (status[1:0] == 2'b11))); // R4
    AST_SINGLE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status[0] ^ status[1])) |-> (status[2] == status[0])); // R6
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy); // R10
endmodule

// File: tb/sim_search_step.sv
`timescale 1ns/1ps
module sim_search_step;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dir_in = 1'b0;
    logic slot_ack = 1'b0;
    logic slot_rbit = 1'b0;
    logic busy, done, err, slot_req, slot_write, slot_wbit;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // responder settings
    logic resp_id = 1'b0, resp_cmp = 1'b0;
    int   resp_lat = 0;
    int   rd_cnt = 0;
    int   wcnt = 0;
    int   stray_req = 0, stray_done = 0;

    // behavioural model state
    int   m_ph = 0;
    logic m_pref = 0, m_id = 0, m_cmp = 0, m_wdir = 0, m_err = 0;
    logic [2:0] m_st = 3'b000;

    always #4 clk = ~clk;

    search_step u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
        .busy(busy), .done(done), .status(status), .err(err),
        .slot_req(slot_req), .slot_write(slot_write), .slot_wbit(slot_wbit),
        .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced from the inputs at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_st = 3'b000; m_err = 0; m_pref = 0; m_wdir = 0;
        end else begin
            case (m_ph)
                0: if (start) begin m_pref = dir_in; m_ph = 1; end
                1: if (slot_ack) begin m_id = slot_rbit; m_ph = 2; end
                2: if (slot_ack) begin
                    m_cmp = slot_rbit;
                    if (m_id && m_cmp) begin
                        m_st = 3'b011; m_err = 1; m_ph = 4;
                    end else begin
                        m_wdir = (m_id != m_cmp) ? m_id : m_pref;
                        m_ph = 3;
                    end
                end
                3: if (slot_ack) begin m_st = {m_wdir, m_cmp, m_id}; m_err = 0; m_ph = 4; end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison and slot responder, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_ph != 0), "R8 busy", busy, m_ph != 0);
            chk(slot_req == (m_ph >= 1 && m_ph <= 3), "R2 slot_req", slot_req, m_ph >= 1 && m_ph <= 3);
            chk(slot_write == (m_ph == 3), "R4 slot_write", slot_write, m_ph == 3);
            if (m_ph == 3) chk(slot_wbit == m_wdir, "R6 slot_wbit", slot_wbit, m_wdir);
            chk(done == (m_ph == 4), "R8 done", done, m_ph == 4);
            chk(status == m_st, "R7 status", status, m_st);
            chk(err == (m_ph == 4 && m_err), "R4 err", err, m_ph == 4 && m_err);
        end
        if (!rst_n) begin
            slot_ack = 0; wcnt = 0;
        end else if (slot_ack) begin
            slot_ack = 0; slot_rbit = 0;
        end else if (stray_req != stray_done) begin
            stray_done++;
            slot_ack = 1; slot_rbit = 1;
        end else if (slot_req) begin
            if (wcnt >= resp_lat) begin
                wcnt = 0;
                slot_ack = 1;
                if (slot_write) slot_rbit = 0;
                else begin
                    slot_rbit = (rd_cnt == 0) ? resp_id : resp_cmp;
                    rd_cnt++;
                end
            end else wcnt++;
        end
    end

    // run one step; expected status derived from the requirement cases
    task automatic step(input logic d, input logic id, input logic cm, input int lat,
                        input bit hold_start, input string tag);
        logic [2:0] exp;
        int n;
        if (id && cm) exp = 3'b011;
        else if (!id && !cm) exp = {d, 2'b00};
        else exp = id ? 3'b101 : 3'b010;
        resp_id = id; resp_cmp = cm; resp_lat = lat; rd_cnt = 0;
        @(negedge clk);
        start = 1; dir_in = d;
        @(negedge clk);
        if (hold_start) dir_in = ~d;
        else start = 0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            if (hold_start) dir_in = ~dir_in;
            n++;
        end
        start = 0;
        chk(done == 1'b1, {tag, " done"}, done, 1);
        chk(status == exp, tag, status, exp);
        chk(err == (exp == 3'b011), {tag, " err"}, err, exp == 3'b011);
        @(negedge clk);
        chk(!busy && !done, {tag, " back idle"}, busy, 0);
        chk(status == exp, "R7 status held", status, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !slot_req && !done && !err && status == 3'b000, "R1 reset state", status, 0);
        rst_n = 1;
        @(negedge clk);
        step(0, 0, 0, 1, 0, "R5 conflict dir0");
        step(1, 0, 0, 0, 0, "R5 conflict dir1");
        step(0, 1, 0, 2, 0, "R6 id1 override");
        step(1, 0, 1, 1, 0, "R6 id0 override");
        step(0, 1, 1, 0, 0, "R4 both ones");
        step(1, 1, 1, 3, 0, "R4 both ones slow");
        step(1, 1, 0, 0, 0, "R3 order id1 cmp0");
        step(0, 0, 1, 4, 0, "R3 order id0 cmp1");
        step(1, 0, 0, 2, 1, "R9 start held dir1");
        step(0, 0, 0, 3, 1, "R9 start held dir0");
        // R10: stray acknowledges while idle
        stray_req = stray_req + 2;
        repeat (6) @(negedge clk);
        chk(!busy && !slot_req, "R10 stray ack ignored", busy, 0);
        chk(status == 3'b000, "R10 status unchanged", status, 0);
        step(1, 0, 0, 0, 0, "R10 step after stray");
        // R1: reset mid-step
        resp_lat = 5; rd_cnt = 0;
        start = 1; dir_in = 1;
        @(negedge clk);
        start = 0;
        repeat (2) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !slot_req && status == 3'b000, "R1 reset mid-step", status, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule